// File: doc/BRIEF.md
# Wake event latch unit

This unit captures events from a group of event sources so that a sleeping system can be woken. Each source is an asynchronous signal, such as an external pin or a request from an internal peripheral. The unit first synchronizes each source. It then latches every edge that matches the direction programmed for that source into a sticky raw status bit.

A per-source enable register decides which latched events may reach the single wake output. The masked status is the raw status ANDed with the enable register. The wake output is high whenever any masked bit is set.

Software reaches the unit through a single-cycle register port. Writes take effect at the clock edge, and reads are combinational from the address. Pending events are cleared by writing ones to the raw status register. Writing back a value just read from that register therefore clears every event it reported.

Top module: `wake_latch_top`

## Requirements
- R1: After reset the enable register (offset 0x0) reads 0, the raw status (offset 0xC) reads 0, `wake_o` is low, and the polarity register (offset 0x4) reads the `POL_RESET` parameter (default 0xF000_0000: sources 28 to 31 rising, all others falling).
- R2: A source whose polarity bit is 1 captures a rising edge, and one whose bit is 0 captures a falling edge. An input change driven before clock edge k shows in raw status after edge k+2 and not before, because of the two-flop synchronizer.
- R3: An edge opposite to the programmed direction leaves the raw bit clear.
- R4: A raw bit latches whether or not its enable bit is set. With its enable bit at 0, that bit cannot raise `wake_o`.
- R5: The masked status (offset 0x8) reads raw AND enable, and `wake_o` is the OR of the masked bits. Enabling a source that has a pending event raises `wake_o` right after the enabling write's clock edge.
- R6: Writing ones to raw status clears those bits, and zero bits in the write data leave their bits unchanged. Writing back the value read clears all pending events and drops `wake_o`.
- R7: When a qualifying edge and a clear of the same bit fall in one cycle, the edge wins and the bit stays set. Other bits in the same write are still cleared.
- R8: Writes to the masked status offset change no register. Reads of offsets other than 0x0, 0x4, 0x8 and 0xC return 0.
- R9: A source held at a steady level through and after reset causes no capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | NUM_SRC | Asynchronous event sources |
| wr_en | input | 1 | Register write strobe, sampled at the clock edge |
| addr | input | ADDR_W | Register byte offset for reads and writes |
| wr_data | input | NUM_SRC | Write data |
| rd_data | output | NUM_SRC | Combinational read data for `addr` |
| wake_o | output | 1 | High while any enabled source has a pending event |

## Verification
On every cycle the assertions check the following. A detected edge is latched on the next clock and beats a clear that arrives in the same cycle. A raw bit never rises without a detected edge, and a clear with no competing edge empties the bit. `wake_o` stays low while every enable bit is 0, and a write to the masked status offset leaves the enable and polarity registers stable. Only the bench's scenarios can show the rest: the exact three-edge capture latency from the pin, the rejection of edges in the wrong direction, and the result of reprogramming polarity. They also show wake rising the moment a pending source is enabled, the bit-selective clearing, the write-back-clears-all idiom, and the read values of unused offsets.

// File: rtl/wk_pkg.sv
package wk_pkg;

  localparam logic [3:0] OFS_ENABLE = 4'h0;
  localparam logic [3:0] OFS_POL    = 4'h4;
  localparam logic [3:0] OFS_MASKED = 4'h8;
  localparam logic [3:0] OFS_RAW    = 4'hC;

  // A sample pair qualifies when it moves in the programmed direction.
  function automatic logic edge_qualifies(input logic pol, input logic cur, input logic prev);
    return pol ? (cur & ~prev) : (~cur & prev);
  endfunction

  // Next raw state: clear requested bits, but a new edge always wins.
  function automatic logic latch_next(input logic raw, input logic clr, input logic hit);
    return (raw & ~clr) | hit;
  endfunction

endpackage

// File: rtl/wk_sync.sv
module wk_sync #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] async_i,
  output logic [NUM_SRC-1:0] cur_o,
  output logic [NUM_SRC-1:0] prev_o,
  output logic               armed_o
);
  localparam int ARM_STAGES = 3;

  logic [ARM_STAGES-1:0] arm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arm_q <= '0;
    else        arm_q <= {arm_q[ARM_STAGES-2:0], 1'b1};
  end
  assign armed_o = arm_q[ARM_STAGES-1];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic meta_q, sync_q, prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= async_i[g];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end
    assign cur_o[g]  = sync_q;
    assign prev_o[g] = prev_q;
  end

endmodule

// File: rtl/wk_edge_latch.sv
module wk_edge_latch #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] cur_i,
  input  logic [NUM_SRC-1:0] prev_i,
  input  logic               armed_i,
  input  logic [NUM_SRC-1:0] pol_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] hit_o,
  output logic [NUM_SRC-1:0] raw_o
);
  import wk_pkg::*;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
    logic raw_q;
    assign hit_o[g] = armed_i & edge_qualifies(pol_i[g], cur_i[g], prev_i[g]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) raw_q <= 1'b0;
      else        raw_q <= latch_next(raw_q, clr_i[g], hit_o[g]);
    end
    assign raw_o[g] = raw_q;
  end

  // Every detected edge is held on the next clock, even against a clear.
  assert_edge_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit_o) |=> ((raw_o & $past(hit_o)) == $past(hit_o)));

  // A raw bit only rises when an edge was detected in the cycle before.
  assert_no_spurious_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw_o & ~$past(raw_o) & ~$past(hit_o)) == '0));

  // A clear with no competing edge empties the bit.
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_i & ~hit_o) != '0) |=> ((raw_o & $past(clr_i & ~hit_o)) == '0));

endmodule

// File: rtl/wk_regs.sv
module wk_regs #(
  parameter int               NUM_SRC   = 32,
  parameter int               ADDR_W    = 4,
  parameter logic [NUM_SRC-1:0] POL_RESET = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [NUM_SRC-1:0] wr_data,
  input  logic [NUM_SRC-1:0] raw_i,
  input  logic [NUM_SRC-1:0] masked_i,
  output logic [NUM_SRC-1:0] en_o,
  output logic [NUM_SRC-1:0] pol_o,
  output logic [NUM_SRC-1:0] clr_o,
  output logic [NUM_SRC-1:0] rd_data
);
  import wk_pkg::*;

  logic sel_en, sel_pol, sel_mask, sel_raw;

  assign sel_en   = (addr == ADDR_W'(OFS_ENABLE));
  assign sel_pol  = (addr == ADDR_W'(OFS_POL));
  assign sel_mask = (addr == ADDR_W'(OFS_MASKED));
  assign sel_raw  = (addr == ADDR_W'(OFS_RAW));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_o  <= '0;
      pol_o <= POL_RESET;
    end else if (wr_en) begin
      if (sel_en)  en_o  <= wr_data;
      if (sel_pol) pol_o <= wr_data;
    end
  end

  assign clr_o = (wr_en && sel_raw) ? wr_data : '0;

  always_comb begin
    rd_data = '0;
    if (sel_en)   rd_data = en_o;
    if (sel_pol)  rd_data = pol_o;
    if (sel_mask) rd_data = masked_i;
    if (sel_raw)  rd_data = raw_i;
  end

  // The masked status offset is read-only.
  assert_masked_ro_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel_mask) |=> ($stable(en_o) && $stable(pol_o)));

endmodule

// File: rtl/wake_latch_top.sv
module wake_latch_top #(
  parameter int                 NUM_SRC   = 32,
  parameter int                 ADDR_W    = 4,
  parameter logic [NUM_SRC-1:0] POL_RESET = NUM_SRC'(32'hF000_0000)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [NUM_SRC-1:0] wr_data,
  output logic [NUM_SRC-1:0] rd_data,
  output logic               wake_o
);
  logic [NUM_SRC-1:0] cur, prev, hit, raw, en, pol, clr, masked;
  logic               armed;

  wk_sync #(.NUM_SRC(NUM_SRC)) i_sync (
    .clk(clk), .rst_n(rst_n), .async_i(src_i),
    .cur_o(cur), .prev_o(prev), .armed_o(armed)
  );

  wk_edge_latch #(.NUM_SRC(NUM_SRC)) i_latch (
    .clk(clk), .rst_n(rst_n), .cur_i(cur), .prev_i(prev), .armed_i(armed),
    .pol_i(pol), .clr_i(clr), .hit_o(hit), .raw_o(raw)
  );

  wk_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .POL_RESET(POL_RESET)) i_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .raw_i(raw), .masked_i(masked), .en_o(en), .pol_o(pol), .clr_o(clr),
    .rd_data(rd_data)
  );

  assign masked = raw & en;
  assign wake_o = |masked;

  // With every source disabled no latched event may wake the system.
  assert_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> !wake_o);

endmodule

// File: tb/test_wake_latch_top.sv
module test_wake_latch_top;
  localparam int NS = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src_i = '1;
  logic          wr_en = 1'b0;
  logic [3:0]    addr = 4'h0;
  logic [NS-1:0] wr_data = '0;
  logic [NS-1:0] rd_data;
  logic          wake_o;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  wake_latch_top i_wake_latch_top (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .wake_o(wake_o)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [NS-1:0] act, input logic [NS-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [NS-1:0] v);
    addr = a;
    #1 v = rd_data;
  endtask

  task automatic wr(input logic [3:0] a, input logic [NS-1:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    step(1);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic t_reset;
    logic [NS-1:0] v;
    step(6);
    rd(4'h0, v); check("R1 enable", v, '0);
    rd(4'h4, v); check("R1 polarity", v, 32'hF000_0000);
    rd(4'hC, v); check("R9 raw after steady inputs", v, '0);
    check("R1 wake", {31'b0, wake_o}, '0);
  endtask

  task automatic t_fall;
    logic [NS-1:0] v;
    src_i[0] = 1'b0;
    step(2);
    rd(4'hC, v); check("R2 not yet latched", v, '0);
    step(1);
    rd(4'hC, v); check("R2 falling captured", v, 32'h1);
    check("R4 disabled no wake", {31'b0, wake_o}, '0);
    src_i[0] = 1'b1;
    step(4);
  endtask

  task automatic t_rise;
    logic [NS-1:0] v;
    src_i[31] = 1'b0;
    step(4);
    rd(4'hC, v); check("R3 opposite edge ignored", v, 32'h1);
    src_i[31] = 1'b1;
    step(3);
    rd(4'hC, v); check("R2 rising captured", v, 32'h8000_0001);
  endtask

  task automatic t_repol;
    logic [NS-1:0] v;
    wr(4'h4, 32'hF000_0020);
    rd(4'h4, v); check("R2 polarity write", v, 32'hF000_0020);
    src_i[5] = 1'b0;
    step(4);
    rd(4'hC, v); check("R3 falling ignored when rising set", v, 32'h8000_0001);
    src_i[5] = 1'b1;
    step(3);
    rd(4'hC, v); check("R2 reprogrammed rising", v, 32'h8000_0021);
  endtask

  task automatic t_enable;
    logic [NS-1:0] v;
    check("R4 pending but disabled", {31'b0, wake_o}, '0);
    wr(4'h0, 32'h20);
    check("R5 wake on enabling pending", {31'b0, wake_o}, 32'h1);
    rd(4'h8, v); check("R5 masked status", v, 32'h20);
  endtask

  task automatic t_ro;
    logic [NS-1:0] v;
    wr(4'h8, '1);
    rd(4'h0, v); check("R8 enable unchanged", v, 32'h20);
    rd(4'h4, v); check("R8 polarity unchanged", v, 32'hF000_0020);
    rd(4'h8, v); check("R8 masked unchanged", v, 32'h20);
    rd(4'h2, v); check("R8 unused offset reads 0", v, '0);
  endtask

  task automatic t_w1c;
    logic [NS-1:0] v;
    wr(4'hC, '0);
    rd(4'hC, v); check("R6 zero write keeps bits", v, 32'h8000_0021);
    wr(4'hC, 32'h1);
    rd(4'hC, v); check("R6 single bit cleared", v, 32'h8000_0020);
    rd(4'hC, v);
    wr(4'hC, v);
    rd(4'hC, v); check("R6 write-back clears all", v, '0);
    check("R6 wake drops", {31'b0, wake_o}, '0);
  endtask

  task automatic t_edge_clear;
    logic [NS-1:0] v;
    src_i[0] = 1'b0;
    step(4);
    src_i[0] = 1'b1;
    src_i[31] = 1'b0;
    step(4);
    rd(4'hC, v); check("R7 setup pending bit 0", v, 32'h1);
    src_i[31] = 1'b1;
    step(2);
    wr(4'hC, 32'h8000_0001);
    rd(4'hC, v); check("R7 edge beats clear", v, 32'h8000_0000);
  endtask

  initial begin
    #20000000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    t_reset();
    t_fall();
    t_rise();
    t_repol();
    t_enable();
    t_ro();
    t_w1c();
    t_edge_clear();
    step(2);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule